// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block performs the byte-lane merge for the left-partial and right-partial word loads and stores of a little-endian 32-bit core. The lowest byte address holds bits 7..0 of a word. A request gives one of four operation kinds, the effective byte address, the aligned memory word (used by loads) and the newest value of the target register. That register value must include any load still waiting in its delay slot. The memory word is only used by loads.

For a load, the block returns the merged register value. The pipeline writes that value back through its delayed-load path. For a store, the block returns one aligned word write: an address with the low two bits cleared, a 4-bit byte-enable mask and lane-positioned write data. All results come from a single register stage. Address generation, memory timing and forwarding are done elsewhere in the pipeline.

Top module: `unaligned_merge`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `valid_o` is 0 and `word_addr_o`, `load_data_o`, `store_be_o` and `store_data_o` are all zero.
- R2: A request with `valid_i` high shows its results with `valid_o` high exactly one clock edge later. An edge with `valid_i` low gives `valid_o` low, and all data outputs keep their previous values.
- R3: Left load (`kind_i` = 2'b00), offset o = `addr_i[1:0]`: byte lane k of `load_data_o` is memory byte k-(3-o) when k >= 3-o. Otherwise it is byte k of `reg_i`.
- R4: Right load (`kind_i` = 2'b01): byte lane k of `load_data_o` is memory byte k+o when k <= 3-o. Otherwise it is byte k of `reg_i`.
- R5: Left store (`kind_i` = 2'b10): `store_be_o` bit j is set for lanes j = 0..o, and lane j of the data is register byte 3-o+j.
- R6: Right store (`kind_i` = 2'b11): `store_be_o` bit j is set for lanes j = o..3, and lane j of the data is register byte j-o.
- R7: `word_addr_o` equals `addr_i` with bits 1..0 cleared, for all four kinds.
- R8: For load kinds, `store_be_o` and `store_data_o` are zero. For store kinds, `load_data_o` is zero.
- R9: In a store result, every byte lane of `store_data_o` whose enable bit is clear is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 2 | 00 left load, 01 right load, 10 left store, 11 right store |
| addr_i | input | AW | Effective byte address |
| mem_word_i | input | 32 | Aligned memory word (loads) |
| reg_i | input | 32 | Newest target-register value |
| valid_o | output | 1 | Results valid |
| word_addr_o | output | AW | Aligned word address |
| load_data_o | output | 32 | Merged load result |
| store_be_o | output | 4 | Store byte enables, bit j = lane j |
| store_data_o | output | 32 | Lane-positioned store data |

## Verification
Every result of this block is due exactly one rising edge after its request. The merged load word, the byte enables, the store data and the aligned address all come from the same single register stage. The bench drives each request on a falling edge and samples all outputs on the next falling edge, which falls between that capturing edge and the following one. In the idle test, the bench changes the inputs while `valid_i` is low and checks at the next falling edge that `valid_o` has dropped and that the data outputs still hold the earlier request's values. All four kinds are covered at all four offsets.

// File: rtl/unaligned_merge.sv
module unaligned_merge #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   mem_word_i,
  input  logic [31:0]   reg_i,
  output logic          valid_o,
  output logic [AW-1:0] word_addr_o,
  output logic [31:0]   load_data_o,
  output logic [3:0]    store_be_o,
  output logic [31:0]   store_data_o
);

  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic [1:0]  off;
  logic [4:0]  sh_left, sh_right;
  logic [31:0] ld_left, ld_right, st_left, st_right;
  logic [3:0]  be_left, be_right;
  logic [31:0] ld_n, sd_n;
  logic [3:0]  be_n;
  logic [1:0]  kind_q;

  assign off      = addr_i[1:0];
  assign sh_left  = {~off, 3'b000};
  assign sh_right = {off, 3'b000};

  assign ld_left  = (mem_word_i << sh_left)  | (reg_i & ~(ALL1 << sh_left));
  assign ld_right = (mem_word_i >> sh_right) | (reg_i & ~(ALL1 >> sh_right));
  assign st_left  = reg_i >> sh_left;
  assign st_right = reg_i << sh_right;
  assign be_left  = 4'b1111 >> ~off;
  assign be_right = 4'b1111 << off;

  always_comb begin
    ld_n = '0;
    sd_n = '0;
    be_n = '0;
    unique case (kind_i)
      2'b00: ld_n = ld_left;
      2'b01: ld_n = ld_right;
      2'b10: begin sd_n = st_left;  be_n = be_left;  end
      default: begin sd_n = st_right; be_n = be_right; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      kind_q       <= 2'b00;
      word_addr_o  <= '0;
      load_data_o  <= '0;
      store_be_o   <= '0;
      store_data_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        kind_q       <= kind_i;
        word_addr_o  <= {addr_i[AW-1:2], 2'b00};
        load_data_o  <= ld_n;
        store_be_o   <= be_n;
        store_data_o <= sd_n;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && $stable(load_data_o) && $stable(store_data_o)));
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (word_addr_o[1:0] == 2'b00 && word_addr_o[AW-1:2] == $past(addr_i[AW-1:2])));
  assert_load_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !kind_q[1]) |-> (store_be_o == 4'b0000 && store_data_o == 32'h0));
  assert_left_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && kind_q == 2'b10) |-> store_be_o[0]);
  assert_right_lane3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && kind_q == 2'b11) |-> store_be_o[3]);
  assert_dead_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && kind_q[1]) |->
      ((store_data_o & ~{{8{store_be_o[3]}}, {8{store_be_o[2]}},
                         {8{store_be_o[1]}}, {8{store_be_o[0]}}}) == 32'h0));

endmodule

// File: tb/test_unaligned_merge.sv
module test_unaligned_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic [31:0] addr_i = '0, mem_word_i = '0, reg_i = '0;
  logic        valid_o;
  logic [31:0] word_addr_o, load_data_o, store_data_o;
  logic [3:0]  store_be_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  unaligned_merge #(.AW(32)) i_unaligned_merge (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
    .addr_i(addr_i), .mem_word_i(mem_word_i), .reg_i(reg_i),
    .valid_o(valid_o), .word_addr_o(word_addr_o), .load_data_o(load_data_o),
    .store_be_o(store_be_o), .store_data_o(store_data_o));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  task automatic run_op(input logic [1:0] kind, input logic [31:0] addr,
                        input logic [31:0] mem, input logic [31:0] rv, input string req);
    int o;
    logic [31:0] exp_ld, exp_sd;
    logic [3:0] exp_be;
    o = int'(addr[1:0]);
    exp_ld = '0; exp_sd = '0; exp_be = '0;
    for (int k = 0; k < 4; k++) begin
      case (kind)
        2'b00: exp_ld[8*k +: 8] = (k >= 3-o) ? byte_of(mem, k-(3-o)) : byte_of(rv, k);
        2'b01: exp_ld[8*k +: 8] = (k <= 3-o) ? byte_of(mem, k+o) : byte_of(rv, k);
        2'b10: if (k <= o) begin exp_be[k] = 1'b1; exp_sd[8*k +: 8] = byte_of(rv, 3-o+k); end
        default: if (k >= o) begin exp_be[k] = 1'b1; exp_sd[8*k +: 8] = byte_of(rv, k-o); end
      endcase
    end
    @(negedge clk);
    valid_i = 1'b1; kind_i = kind; addr_i = addr; mem_word_i = mem; reg_i = rv;
    @(negedge clk);
    valid_i = 1'b0;
    check(valid_o === 1'b1, {req, " R2 valid"}, {31'b0, valid_o}, 32'h1);
    check(word_addr_o === {addr[31:2], 2'b00}, {req, " R7 addr"}, word_addr_o, {addr[31:2], 2'b00});
    check(load_data_o === exp_ld, {req, " load data"}, load_data_o, exp_ld);
    check(store_be_o === exp_be, {req, " byte enables"}, {28'b0, store_be_o}, {28'b0, exp_be});
    check(store_data_o === exp_sd, {req, " store data R9"}, store_data_o, exp_sd);
  endtask

  task automatic t_reset;
    check(valid_o === 1'b0, "R1 valid", {31'b0, valid_o}, 32'h0);
    check(word_addr_o === 32'h0 && load_data_o === 32'h0, "R1 addr/load", load_data_o, 32'h0);
    check(store_be_o === 4'h0 && store_data_o === 32'h0, "R1 store", store_data_o, 32'h0);
  endtask

  task automatic t_kind(input logic [1:0] kind, input string req);
    for (int o = 0; o < 4; o++) begin
      run_op(kind, 32'h8001_2340 | o, 32'hA1B2_C3D4, 32'h1122_3344, req);
      run_op(kind, 32'h0000_0FF8 | o, 32'hDEAD_BEEF, 32'h5566_7788, req);
    end
  endtask

  task automatic t_idle;
    logic [31:0] held_ld, held_sd;
    run_op(2'b00, 32'h100, 32'hCAFE_F00D, 32'h0BAD_1DEA, "R3 pre-idle");
    held_ld = load_data_o;
    run_op(2'b11, 32'h202, 32'h0, 32'h1234_5678, "R6 pre-idle");
    held_ld = load_data_o;
    held_sd = store_data_o;
    kind_i = 2'b01; addr_i = 32'hFFFF_FFFF; reg_i = 32'h9999_9999; mem_word_i = 32'h7777_7777;
    @(negedge clk);
    check(valid_o === 1'b0, "R2 idle valid", {31'b0, valid_o}, 32'h0);
    check(load_data_o === held_ld, "R2 idle load hold", load_data_o, held_ld);
    check(store_data_o === held_sd, "R2 idle store hold", store_data_o, held_sd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_kind(2'b00, "R3 left load R8");
    t_kind(2'b01, "R4 right load R8");
    t_kind(2'b10, "R5 left store R8");
    t_kind(2'b11, "R6 right store R8");
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule